// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between a clocked host and an external asynchronous static RAM of 32K words by 8 bits. The host hands it one word access at a time through a request/ready handshake. The controller then plays out the strobe sequence the memory needs, with every phase counted in whole clock cycles. After a read it returns the sampled byte with a one-cycle valid pulse.

The memory side carries the address, three active-low strobes (chip select, output enable and write strobe) and one shared byte lane. That lane is split into an outgoing value, a drive enable for the bidirectional pad, and the value the pad returns. Every wait count is a parameter, worked out by the integrator from the clock period and the memory's speed grade.

A write keeps output enable high throughout. The controller waits a turnaround count after the write strobe falls before it drives the lane. It then holds the data stable for the setup count before the write strobe rises. Between accesses the chip select returns high, which puts the memory into standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1 (all three strobes are active low), `mem_dq_oe` is 0, `host_ready` is 1 and `host_rvalid` is 0.
- R2: Whenever `host_ready` is 1, the memory is in standby: `mem_ce_n` = 1, `mem_we_n` = 1 and `mem_dq_oe` = 0. With `host_req` held high, consecutive accesses are separated by exactly one such standby cycle.
- R3: A read holds `mem_ce_n` = 0, `mem_oe_n` = 0, `mem_we_n` = 1 and `mem_dq_oe` = 0 for the RD_WAIT cycles that follow acceptance, with `mem_addr` equal to the accepted address.
- R4: Read data is sampled from `mem_dq_i` on the clock edge that ends the RD_WAIT-th read cycle. It appears on `host_rdata` with `host_rvalid` high for exactly one cycle, RD_WAIT+1 cycles after the accepting edge. A write never raises `host_rvalid`.
- R5: During a write, `mem_oe_n` stays 1, `mem_ce_n` stays 0 and `mem_addr` does not change.
- R6: During the first TURN_CYC cycles with `mem_we_n` low, `mem_dq_oe` is 0.
- R7: `mem_we_n` stays low for TURN_CYC + max(DSETUP_CYC, WE_MIN_CYC − TURN_CYC) cycles. The write data is driven and unchanged for at least the last DSETUP_CYC of them.
- R8: For one cycle after `mem_we_n` rises, `mem_ce_n` stays 0 and both the data and the address are still driven. The drive is then released together with the chip select. `mem_dq_oe` is never 1 while the memory may be driving the lane.
- R9: A request is taken on a clock edge where both `host_req` and `host_ready` are 1. `host_ready` is then 0 for RD_WAIT cycles on a read, or for TURN_CYC + max(DSETUP_CYC, WE_MIN_CYC − TURN_CYC) + 1 cycles on a write.
- R10: Address, write flag (`host_wr` = 1 for a write) and write data are captured at acceptance. Changes on those host inputs while the access is in progress have no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_req | input | 1 | Access request |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Word address |
| host_wdata | input | DATA_W | Write byte |
| host_ready | output | 1 | Controller idle, request can be taken |
| host_rdata | output | DATA_W | Read byte |
| host_rvalid | output | 1 | One-cycle pulse marking `host_rdata` valid |
| mem_addr | output | ADDR_W | Memory address lines |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dq_o | output | DATA_W | Byte driven onto the shared lane |
| mem_dq_oe | output | 1 | Pad drive enable for `mem_dq_o` |
| mem_dq_i | input | DATA_W | Byte seen on the shared lane |

## Verification
The controller is exercised with writes to the lowest and highest addresses and to addresses with mixed upper bits, and with overwrites of a location followed by reads in a different order. A location read back after it is rewritten shows that each write landed at the captured address, and not at the value the host bus held during the access. The memory model releases valid read data only after the access time has passed. A read that samples too early therefore returns a marker byte, which separates a correct sampling edge from an early one. A request held high back to back shows the single standby cycle between accesses. The model's per-write checks on output-enable level, turnaround, pulse length, setup and hold separate the write phases from each other.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_WTURN = 3'd2,
    ST_WDATA = 3'd3,
    ST_WHOLD = 3'd4
  } seq_st_t;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wait_timer.sv
`timescale 1ns/1ps
module sram_wait_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/sram_seq.sv
`timescale 1ns/1ps
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int RD_WAIT  = 3,
  parameter int TURN_CYC = 2,
  parameter int DATA_CYC = 2,
  parameter int CW       = 3
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    req,
  input  logic    wr,
  output seq_st_t st_nxt,
  output logic    accept,
  output logic    capture,
  output logic    ready
);

  localparam logic [CW-1:0] LD_RD   = CW'(RD_WAIT - 1);
  localparam logic [CW-1:0] LD_TURN = CW'(TURN_CYC - 1);
  localparam logic [CW-1:0] LD_DATA = CW'(DATA_CYC - 1);

  seq_st_t       st;
  logic          t_load;
  logic [CW-1:0] t_val;
  logic          t_done;

  sram_wait_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_done)
  );

  always_comb begin
    st_nxt = st;
    t_load = 1'b0;
    t_val  = '0;
    case (st)
      ST_IDLE: begin
        if (req) begin
          t_load = 1'b1;
          if (wr) begin
            st_nxt = ST_WTURN;
            t_val  = LD_TURN;
          end else begin
            st_nxt = ST_READ;
            t_val  = LD_RD;
          end
        end
      end
      ST_READ: begin
        if (t_done) st_nxt = ST_IDLE;
      end
      ST_WTURN: begin
        if (t_done) begin
          st_nxt = ST_WDATA;
          t_load = 1'b1;
          t_val  = LD_DATA;
        end
      end
      ST_WDATA: begin
        if (t_done) st_nxt = ST_WHOLD;
      end
      ST_WHOLD: st_nxt = ST_IDLE;
      default:  st_nxt = ST_IDLE;
    endcase
  end

  assign accept  = (st == ST_IDLE) && req;
  assign capture = (st == ST_READ) && t_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      ready <= 1'b1;
    end else begin
      st    <= st_nxt;
      ready <= (st_nxt == ST_IDLE);
    end
  end

endmodule

// File: rtl/sram_io_regs.sv
`timescale 1ns/1ps
module sram_io_regs
  import sram_ctrl_pkg::*;
#(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  seq_st_t       st_nxt,
  input  logic          accept,
  input  logic          capture,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_wdata,
  input  logic [DW-1:0] dq_i,
  output logic [AW-1:0] addr_q,
  output logic          ce_n_q,
  output logic          oe_n_q,
  output logic          we_n_q,
  output logic [DW-1:0] dq_q,
  output logic          dq_oe_q,
  output logic [DW-1:0] rdata_q,
  output logic          rvalid_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      ce_n_q   <= 1'b1;
      oe_n_q   <= 1'b1;
      we_n_q   <= 1'b1;
      dq_q     <= '0;
      dq_oe_q  <= 1'b0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      ce_n_q   <= (st_nxt == ST_IDLE);
      oe_n_q   <= (st_nxt != ST_READ);
      we_n_q   <= !((st_nxt == ST_WTURN) || (st_nxt == ST_WDATA));
      dq_oe_q  <= (st_nxt == ST_WDATA) || (st_nxt == ST_WHOLD);
      rvalid_q <= capture;
      if (accept) begin
        addr_q <= in_addr;
        dq_q   <= in_wdata;
      end
      if (capture) rdata_q <= dq_i;
    end
  end

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int RD_WAIT    = 3,
  parameter int TURN_CYC   = 2,
  parameter int DSETUP_CYC = 2,
  parameter int WE_MIN_CYC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ready,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int DATA_CYC = max_int(DSETUP_CYC, WE_MIN_CYC - TURN_CYC);
  localparam int MAX_CYC  = max_int(RD_WAIT, max_int(TURN_CYC, DATA_CYC));
  localparam int CW       = max_int(1, $clog2(MAX_CYC + 1));

  seq_st_t st_nxt;
  logic    accept;
  logic    capture;

  sram_seq #(
    .RD_WAIT  (RD_WAIT),
    .TURN_CYC (TURN_CYC),
    .DATA_CYC (DATA_CYC),
    .CW       (CW)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .req     (host_req),
    .wr      (host_wr),
    .st_nxt  (st_nxt),
    .accept  (accept),
    .capture (capture),
    .ready   (host_ready)
  );

  sram_io_regs #(
    .AW (ADDR_W),
    .DW (DATA_W)
  ) u_io (
    .clk      (clk),
    .rst      (rst),
    .st_nxt   (st_nxt),
    .accept   (accept),
    .capture  (capture),
    .in_addr  (host_addr),
    .in_wdata (host_wdata),
    .dq_i     (mem_dq_i),
    .addr_q   (mem_addr),
    .ce_n_q   (mem_ce_n),
    .oe_n_q   (mem_oe_n),
    .we_n_q   (mem_we_n),
    .dq_q     (mem_dq_o),
    .dq_oe_q  (mem_dq_oe),
    .rdata_q  (host_rdata),
    .rvalid_q (host_rvalid)
  );

endmodule

// File: rtl/sram_async_ctrl_chk.sv
`timescale 1ns/1ps
module sram_async_ctrl_chk #(
  parameter int AW = 15,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          host_req,
  input logic          host_ready,
  input logic          host_rvalid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic [DW-1:0] mem_dq_o,
  input logic          mem_dq_oe
);

  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && host_ready && !host_rvalid));

  a_r2_standby: assert property (@(posedge clk) disable iff (rst)
    host_ready |-> (mem_ce_n && mem_we_n && !mem_dq_oe));

  a_r3_read_strobes: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n && !mem_dq_oe));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    host_rvalid |=> !host_rvalid);

  a_r5_write_oe_high: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n));

  a_r6_turnaround: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> !mem_dq_oe);

  a_r7_data_stable: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && !$past(mem_we_n) && mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_o));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n && $stable(mem_addr) && $stable(mem_dq_o)));

  a_r9_busy: assert property (@(posedge clk) disable iff (rst)
    (host_req && host_ready) |=> !host_ready);

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.AW(ADDR_W), .DW(DATA_W)) u_chk (.*);

// File: tb/sram_async_ctrl_tb.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb;

  localparam int AW = 15;
  localparam int DW = 8;
  localparam int RD_WAIT = 3;
  localparam int TURN = 2;
  localparam int DSETUP = 2;
  localparam int WE_MIN = 3;
  localparam int ACC_CYC = 3;
  localparam int DATA_CYC = (WE_MIN > TURN + DSETUP) ? WE_MIN - TURN : DSETUP;
  localparam int RD_LAT = RD_WAIT + 1;
  localparam int WR_LAT = TURN + DATA_CYC + 2;

  typedef struct packed {
    logic          w;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 15'h0000, 8'h3C},
    '{1'b1, 15'h7FFF, 8'hC3},
    '{1'b1, 15'h2A55, 8'h96},
    '{1'b1, 15'h5580, 8'h01},
    '{1'b0, 15'h0000, 8'h3C},
    '{1'b0, 15'h7FFF, 8'hC3},
    '{1'b1, 15'h0000, 8'hE7},
    '{1'b0, 15'h2A55, 8'h96},
    '{1'b0, 15'h0000, 8'hE7},
    '{1'b0, 15'h5580, 8'h01},
    '{1'b1, 15'h1234, 8'hFE},
    '{1'b0, 15'h1234, 8'hFE},
    '{1'b0, 15'h7FFF, 8'hC3}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic          wr = 1'b0;
  logic [AW-1:0] haddr = '0;
  logic [DW-1:0] hwdata = '0;
  logic          ready;
  logic [DW-1:0] rdata;
  logic          rvalid;
  logic [AW-1:0] maddr;
  logic          ce_n, oe_n, we_n;
  logic [DW-1:0] dq_o;
  logic          dq_oe;
  logic [DW-1:0] dq_i;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  sram_async_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .RD_WAIT(RD_WAIT),
    .TURN_CYC(TURN), .DSETUP_CYC(DSETUP), .WE_MIN_CYC(WE_MIN)
  ) u_dut (
    .clk(clk), .rst(rst), .host_req(req), .host_wr(wr),
    .host_addr(haddr), .host_wdata(hwdata), .host_ready(ready),
    .host_rdata(rdata), .host_rvalid(rvalid), .mem_addr(maddr),
    .mem_ce_n(ce_n), .mem_oe_n(oe_n), .mem_we_n(we_n),
    .mem_dq_o(dq_o), .mem_dq_oe(dq_oe), .mem_dq_i(dq_i)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural memory model ----------------
  logic [DW-1:0] mdata [256];
  logic [6:0]    mtag  [256];
  logic          mval  [256];
  logic          prev_read = 1'b0;
  int            rd_age = 0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] mem_q = 8'h00;
  logic          wr_was = 1'b0;
  int            wr_cnt = 0;
  int            set_cnt = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_last = '0;
  logic          addr_ok = 1'b1, oe_ok = 1'b1, turn_ok = 1'b1;

  wire readcond = !ce_n && !oe_n && we_n;
  wire wact = !ce_n && !we_n;

  assign dq_i = dq_oe ? dq_o : ((readcond || prev_read) ? mem_q : 8'h00);

  initial begin
    for (int i = 0; i < 256; i++) begin
      mdata[i] = '0;
      mtag[i] = '0;
      mval[i] = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rst) begin
      prev_read = 1'b0;
      rd_age = 0;
      wr_was = 1'b0;
    end else begin
      // R8: controller must not drive while the memory may still drive
      if (dq_oe && (readcond || prev_read)) chk(1'b0, "R8 contention", 1, 0);
      if (wact) begin
        if (!wr_was) begin
          wr_cnt = 1;
          wr_addr = maddr;
          addr_ok = 1'b1;
          oe_ok = oe_n;
          turn_ok = !dq_oe;
          set_cnt = dq_oe ? 1 : 0;
        end else begin
          wr_cnt++;
          addr_ok = addr_ok && (maddr == wr_addr);
          oe_ok = oe_ok && oe_n;
          if (wr_cnt <= TURN) turn_ok = turn_ok && !dq_oe;
          if (dq_oe && set_cnt > 0 && dq_o == wr_last) set_cnt++;
          else set_cnt = dq_oe ? 1 : 0;
        end
        wr_last = dq_o;
      end else if (wr_was) begin
        chk(oe_ok, "R5 oe high in write", int'(oe_ok), 1);
        chk(addr_ok, "R5 address stable in write", int'(addr_ok), 1);
        chk(turn_ok, "R6 turnaround", int'(turn_ok), 1);
        chk(wr_cnt >= WE_MIN, "R7 write pulse", wr_cnt, WE_MIN);
        chk(set_cnt >= DSETUP, "R7 data setup", set_cnt, DSETUP);
        chk(dq_oe && dq_o == wr_last && maddr == wr_addr && !ce_n, "R8 hold",
            int'(dq_oe), 1);
        mdata[wr_addr[7:0]] = wr_last;
        mtag[wr_addr[7:0]] = wr_addr[14:8];
        mval[wr_addr[7:0]] = 1'b1;
      end
      wr_was = wact;
      if (readcond) begin
        if (prev_read && maddr == rd_addr) rd_age++;
        else rd_age = 1;
        rd_addr = maddr;
      end else begin
        rd_age = 0;
      end
      prev_read = readcond;
      if (rd_age >= ACC_CYC)
        mem_q = (mval[rd_addr[7:0]] && mtag[rd_addr[7:0]] == rd_addr[14:8])
                ? mdata[rd_addr[7:0]] : 8'hEE;
      else
        mem_q = 8'hA5;
    end
  end

  // ---------------- host access task ----------------
  task automatic do_op(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       output logic [DW-1:0] rd, output int lat, output bit rv,
                       output bit strobes_ok);
    @(negedge clk);
    req = 1'b1;
    wr = w;
    haddr = a;
    hwdata = d;
    @(negedge clk);
    req = 1'b0;
    haddr = ~a;     // R10: scramble host inputs while busy
    hwdata = ~d;
    wr = ~w;
    lat = 1;
    strobes_ok = 1'b1;
    while (!ready && lat < 100) begin
      if (!w) strobes_ok = strobes_ok && !ce_n && !oe_n && we_n && !dq_oe && (maddr == a);
      @(negedge clk);
      lat++;
    end
    rd = rdata;
    rv = rvalid;
  endtask

  initial begin
    logic [DW-1:0] rd;
    int lat;
    bit rv, sok;
    int pulses;
    bit sb_ok;

    repeat (3) @(negedge clk);
    // R1 during reset
    chk(ce_n && oe_n && we_n && !dq_oe && ready && !rvalid, "R1 in reset",
        {ce_n, oe_n, we_n, dq_oe, ready, rvalid}, 6'b111010);
    rst = 1'b0;
    @(negedge clk);
    chk(ce_n && oe_n && we_n && !dq_oe && ready && !rvalid, "R1 after reset",
        {ce_n, oe_n, we_n, dq_oe, ready, rvalid}, 6'b111010);

    // R2 idle standby
    sb_ok = 1'b1;
    repeat (4) begin
      @(negedge clk);
      sb_ok = sb_ok && ce_n && we_n && !dq_oe && ready;
    end
    chk(sb_ok, "R2 idle standby", int'(sb_ok), 1);

    // vector table
    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i].w, VEC[i].a, VEC[i].d, rd, lat, rv, sok);
      if (VEC[i].w) begin
        chk(lat == WR_LAT, "R9 write busy length", lat, WR_LAT);
        chk(!rv, "R4 no rvalid on write", int'(rv), 0);
      end else begin
        chk(lat == RD_LAT, "R9 read busy length", lat, RD_LAT);
        chk(sok, "R3 read strobes", int'(sok), 1);
        chk(rv, "R4 rvalid with data", int'(rv), 1);
        chk(rd == VEC[i].d, "R4 R10 read data", rd, VEC[i].d);
      end
      @(negedge clk);
      chk(!rvalid, "R4 single pulse", int'(rvalid), 0);
      chk(ce_n && ready, "R2 standby after access", {ce_n, ready}, 2'b11);
    end

    // R2: back-to-back reads with request held high
    @(negedge clk);
    req = 1'b1;
    wr = 1'b0;
    haddr = 15'h2A55;
    pulses = 0;
    sb_ok = 1'b1;
    for (int k = 1; k <= 2 * RD_LAT; k++) begin
      @(negedge clk);
      if (rvalid) begin
        pulses++;
        sb_ok = sb_ok && ce_n && (rdata == 8'h96);
      end
    end
    req = 1'b0;
    chk(pulses == 2, "R2 back-to-back count", pulses, 2);
    chk(sb_ok, "R2 standby cycle between accesses", int'(sb_ok), 1);

    repeat (RD_LAT + 2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule